// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the arithmetic and flag engine of an 8-bit accumulator processor. Each valid cycle it takes the accumulator, one operand byte, a 5-bit operation code and the current packed flag byte. One clock later it returns the new accumulator value and the new flag byte. The flags are sign, zero, auxiliary (half) carry, even parity and carry. A 16-bit register-pair adder runs beside it. That adder returns the pair sum and touches only the carry flag.

The operand fetch and the register file stay outside the block. The caller picks the operand and writes the result back. Every operation either updates a flag or passes it through unchanged. The flag byte at the output can therefore be stored directly as the next flag state.

Top module: `acc_alu_flags`

## Requirements
- R1: The flag byte holds sign in bit 7, zero in bit 6, auxiliary carry in bit 4, parity in bit 2 and carry in bit 0. Bit 1 always reads 1, and bits 3 and 5 always read 0. Outputs are registered and appear on the cycle after `in_valid`, together with `out_valid`. Reset clears `out_valid`, `result` and `pair_sum` and sets `flags_out` to 0x02.
- R2: Add (code 0) and add-with-carry (code 1, carry-in = flag C) return the low 8 bits of acc+operand+cin. C is set when the 9-bit sum exceeds 0xFF, and AC is set when the low-nibble sum plus cin exceeds 0xF. S is result bit 7, Z is set when the result is 0, and P is set when the result has an even number of ones.
- R3: Subtract (code 2) and subtract-with-borrow (code 3, borrow-in = flag C) return acc−operand−bin. C is set on a borrow out of bit 7 and AC on a borrow out of bit 3. S, Z and P are set as in R2.
- R4: Compare (code 4) sets every flag exactly as subtract does, and `result` equals the unchanged accumulator.
- R5: AND (code 5), XOR (code 6) and OR (code 7) clear C and AC and set S, Z and P from the result.
- R6: Increment (code 8) and decrement (code 9) set S, Z and P from the result. AC is set on a carry out of bit 3 for increment and on a borrow out of bit 3 for decrement. C keeps its input value.
- R7: Rotate-left (code 10) copies bit 7 into C and into bit 0. Rotate-right (code 11) copies bit 0 into C and into bit 7. Rotate-left-through-carry (code 12) and rotate-right-through-carry (code 13) shift the old C in and the exiting bit out to C. S, Z, AC and P keep their input values.
- R8: Complement (code 14) inverts the accumulator and keeps every flag. Set-carry (code 15) and complement-carry (code 16) change only C, and `result` equals the accumulator.
- R9: Decimal adjust (code 17) first adds 0x06 when the low nibble is above 9 or AC is set. AC becomes the carry out of that low-nibble addition. It then adds 0x60 when the high nibble is above 9, C is set, or the first step overflowed. C becomes 1 when it was 1 or either step overflowed. S, Z and P come from the adjusted result.
- R10: Pair add (code 18) outputs `pair_a`+`pair_b` modulo 2^16 on `pair_sum`. C is set when the sum exceeds 0xFFFF, every other flag keeps its value, and `result` equals the accumulator.
- R11: Codes 19 to 31 return the accumulator and the input flags unchanged, with bits 1, 3 and 5 forced as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| op_in | input | 5 | Operation code (see requirements) |
| acc_in | input | DATA_W | Accumulator value |
| opnd_in | input | DATA_W | Operand byte |
| flags_in | input | 8 | Current packed flag byte |
| pair_a | input | PAIR_W | First register pair for pair add |
| pair_b | input | PAIR_W | Second register pair for pair add |
| out_valid | output | 1 | Result registered this cycle |
| result | output | DATA_W | New accumulator value |
| flags_out | output | 8 | New packed flag byte |
| pair_sum | output | PAIR_W | Registered pair sum |

## Verification
The hardest state to reach is a decimal adjust in which both correction steps fire. This includes the case where the low-nibble correction itself carries into the high nibble, and the case where only an incoming AC or C flag triggers a correction. The stimulus builds these cases with directed flag bytes rather than by hoping an earlier add left them behind: 0x9A, 0x02 with AC preset, and 0x15 with C preset. A random stream then drives all other codes against arbitrary flag bytes, with bits 1, 3 and 5 set to garbage. This checks that unchanged flags really pass through and that the fixed bits are forced.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OP_W   = 5;
  localparam int FLAG_W = 8;
  localparam int NIB    = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_XOR = 5'd6,  OP_OR  = 5'd7,
    OP_INC = 5'd8,  OP_DEC = 5'd9,  OP_RLC = 5'd10, OP_RRC = 5'd11,
    OP_RAL = 5'd12, OP_RAR = 5'd13, OP_CMA = 5'd14, OP_STC = 5'd15,
    OP_CMC = 5'd16, OP_DAA = 5'd17, OP_DAD = 5'd18
  } alu_op_e;

  localparam int FB_S  = 7;
  localparam int FB_Z  = 6;
  localparam int FB_AC = 4;
  localparam int FB_P  = 2;
  localparam int FB_C  = 0;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic c;
  } flags_t;

  function automatic logic [FLAG_W-1:0] pack_flags(flags_t f);
    logic [FLAG_W-1:0] b;
    b        = 8'h02;
    b[FB_S]  = f.s;
    b[FB_Z]  = f.z;
    b[FB_AC] = f.ac;
    b[FB_P]  = f.p;
    b[FB_C]  = f.c;
    return b;
  endfunction

  function automatic flags_t unpack_flags(logic [FLAG_W-1:0] b);
    flags_t f;
    f.s  = b[FB_S];
    f.z  = b[FB_Z];
    f.ac = b[FB_AC];
    f.p  = b[FB_P];
    f.c  = b[FB_C];
    return f;
  endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              c_in,
  output logic [DATA_W-1:0] res,
  output flags_t            fout
);

  logic              is_sub, is_unit, use_cin, cin;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   sum_w, dif_w;
  logic [NIB:0]      lo_sum, lo_dif;
  logic [DATA_W-1:0] val;

  always_comb begin
    is_sub  = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP) || (op == OP_DEC);
    is_unit = (op == OP_INC) || (op == OP_DEC);
    use_cin = (op == OP_ADC) || (op == OP_SBB);
    cin     = use_cin & c_in;
    b_eff   = is_unit ? DATA_W'(1) : b;

    sum_w  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
    dif_w  = {1'b0, a} - {1'b0, b_eff} - {{DATA_W{1'b0}}, cin};
    lo_sum = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, cin};
    lo_dif = {1'b0, a[NIB-1:0]} - {1'b0, b_eff[NIB-1:0]} - {{NIB{1'b0}}, cin};

    val    = is_sub ? dif_w[DATA_W-1:0] : sum_w[DATA_W-1:0];
    res    = (op == OP_CMP) ? a : val;

    fout.s  = val[DATA_W-1];
    fout.z  = (val == '0);
    fout.p  = ~^val;
    fout.ac = is_sub ? lo_dif[NIB] : lo_sum[NIB];
    if (is_unit)     fout.c = c_in;
    else if (is_sub) fout.c = dif_w[DATA_W];
    else             fout.c = sum_w[DATA_W];
  end

endmodule

// File: rtl/alu_logic_rot.sv
module alu_logic_rot
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  flags_t            fin,
  output logic [DATA_W-1:0] res,
  output flags_t            fout
);

  localparam int MSB = DATA_W - 1;

  logic is_bool;

  always_comb begin
    res     = a;
    fout    = fin;
    is_bool = 1'b0;
    case (op)
      OP_AND: begin res = a & b; is_bool = 1'b1; end
      OP_XOR: begin res = a ^ b; is_bool = 1'b1; end
      OP_OR:  begin res = a | b; is_bool = 1'b1; end
      OP_RLC: begin res = {a[MSB-1:0], a[MSB]}; fout.c = a[MSB]; end
      OP_RRC: begin res = {a[0], a[MSB:1]};     fout.c = a[0];   end
      OP_RAL: begin res = {a[MSB-1:0], fin.c};  fout.c = a[MSB]; end
      OP_RAR: begin res = {fin.c, a[MSB:1]};    fout.c = a[0];   end
      OP_CMA: res = ~a;
      OP_STC: fout.c = 1'b1;
      OP_CMC: fout.c = ~fin.c;
      default: ;
    endcase
    if (is_bool) begin
      fout.s  = res[MSB];
      fout.z  = (res == '0);
      fout.p  = ~^res;
      fout.ac = 1'b0;
      fout.c  = 1'b0;
    end
  end

endmodule

// File: rtl/alu_dec_adjust.sv
module alu_dec_adjust
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic              ac_in,
  input  logic              c_in,
  output logic [DATA_W-1:0] res,
  output flags_t            fout
);

  localparam int             DIGIT_MAX = 9;
  localparam logic [DATA_W:0] LO_FIX   = (DATA_W+1)'(6);
  localparam logic [DATA_W:0] HI_FIX   = (DATA_W+1)'(6) << NIB;

  logic              lo_fire, hi_fire;
  logic [NIB:0]      lo_probe;
  logic [DATA_W:0]   step1, step2;

  always_comb begin
    lo_fire  = (a[NIB-1:0] > NIB'(DIGIT_MAX)) || ac_in;
    lo_probe = {1'b0, a[NIB-1:0]} + (NIB+1)'(6);
    step1    = {1'b0, a} + (lo_fire ? LO_FIX : '0);
    hi_fire  = (step1[DATA_W-1:NIB] > (DATA_W-NIB)'(DIGIT_MAX)) || c_in || step1[DATA_W];
    step2    = {1'b0, step1[DATA_W-1:0]} + (hi_fire ? HI_FIX : '0);
    res      = step2[DATA_W-1:0];

    fout.ac = lo_fire & lo_probe[NIB];
    fout.c  = c_in | step1[DATA_W] | step2[DATA_W];
    fout.s  = res[DATA_W-1];
    fout.z  = (res == '0);
    fout.p  = ~^res;
  end

endmodule

// File: rtl/alu_pair_add.sv
module alu_pair_add #(
  parameter int PAIR_W = 16
) (
  input  logic [PAIR_W-1:0] a,
  input  logic [PAIR_W-1:0] b,
  output logic [PAIR_W-1:0] sum,
  output logic              cout
);

  logic [PAIR_W:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b};
    sum  = wide[PAIR_W-1:0];
    cout = wide[PAIR_W];
  end

endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PAIR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   op_in,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opnd_in,
  input  logic [FLAG_W-1:0] flags_in,
  input  logic [PAIR_W-1:0] pair_a,
  input  logic [PAIR_W-1:0] pair_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags_out,
  output logic [PAIR_W-1:0] pair_sum
);

  localparam logic [FLAG_W-1:0] FLAG_RST  = 8'h02;
  localparam logic [FLAG_W-1:0] KEEP_MASK = 8'b1101_0100;

  alu_op_e           op;
  flags_t            fin, f_ar, f_lg, f_da, f_nx;
  logic [DATA_W-1:0] r_ar, r_lg, r_da, r_nx;
  logic [PAIR_W-1:0] p_sum;
  logic              p_cout;
  logic              unused_flag_bits;
  alu_op_e           op_q;

  assign op  = alu_op_e'(op_in);
  assign fin = unpack_flags(flags_in);
  assign unused_flag_bits = ^{flags_in[5], flags_in[3], flags_in[1]};

  alu_arith #(.DATA_W(DATA_W)) u_arith (
    .op(op), .a(acc_in), .b(opnd_in), .c_in(fin.c), .res(r_ar), .fout(f_ar)
  );

  alu_logic_rot #(.DATA_W(DATA_W)) u_logic (
    .op(op), .a(acc_in), .b(opnd_in), .fin(fin), .res(r_lg), .fout(f_lg)
  );

  alu_dec_adjust #(.DATA_W(DATA_W)) u_daa (
    .a(acc_in), .ac_in(fin.ac), .c_in(fin.c), .res(r_da), .fout(f_da)
  );

  alu_pair_add #(.PAIR_W(PAIR_W)) u_pair (
    .a(pair_a), .b(pair_b), .sum(p_sum), .cout(p_cout)
  );

  always_comb begin
    r_nx = acc_in;
    f_nx = fin;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP, OP_INC, OP_DEC: begin
        r_nx = r_ar;
        f_nx = f_ar;
      end
      OP_AND, OP_XOR, OP_OR, OP_RLC, OP_RRC, OP_RAL, OP_RAR,
      OP_CMA, OP_STC, OP_CMC: begin
        r_nx = r_lg;
        f_nx = f_lg;
      end
      OP_DAA: begin
        r_nx = r_da;
        f_nx = f_da;
      end
      OP_DAD: f_nx.c = p_cout;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags_out <= FLAG_RST;
      pair_sum  <= '0;
      op_q      <= OP_ADD;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result    <= r_nx;
        flags_out <= pack_flags(f_nx);
        pair_sum  <= p_sum;
        op_q      <= op;
      end
    end
  end

  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flags_out[1] && !flags_out[3] && !flags_out[5])); // R1

  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_CMP) |=> (result == $past(acc_in))); // R4

  AST_BOOL_CLEARS_CARRY: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (op_q == OP_AND || op_q == OP_XOR || op_q == OP_OR))
      |-> (!flags_out[FB_C] && !flags_out[FB_AC])); // R5

  AST_STEP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == OP_INC || op == OP_DEC))
      |=> (flags_out[FB_C] == $past(flags_in[FB_C]))); // R6

  AST_ROT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op == OP_RLC || op == OP_RRC || op == OP_RAL || op == OP_RAR))
      |=> ((flags_out & KEEP_MASK) == ($past(flags_in) & KEEP_MASK))); // R7

  AST_PAIR_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_DAD)
      |=> (((flags_out & KEEP_MASK) == ($past(flags_in) & KEEP_MASK))
           && result == $past(acc_in))); // R10

  AST_ZERO_MATCHES: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (op_q == OP_ADD || op_q == OP_SUB || op_q == OP_AND || op_q == OP_INC))
      |-> (flags_out[FB_Z] == (result == '0))); // R2

endmodule

// File: tb/acc_alu_flags_tb_top.sv
`timescale 1ns/1ps
module acc_alu_flags_tb_top;

  localparam int DW = 8;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [4:0]    op_in = '0;
  logic [DW-1:0] acc_in = '0, opnd_in = '0;
  logic [7:0]    flags_in = '0;
  logic [PW-1:0] pair_a = '0, pair_b = '0;
  logic          out_valid;
  logic [DW-1:0] result;
  logic [7:0]    flags_out;
  logic [PW-1:0] pair_sum;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [7:0]  r;
    logic [7:0]  f;
    logic [15:0] p;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  acc_alu_flags #(.DATA_W(DW), .PAIR_W(PW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_in(op_in),
    .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
    .pair_a(pair_a), .pair_b(pair_b), .out_valid(out_valid),
    .result(result), .flags_out(flags_out), .pair_sum(pair_sum)
  );

  function automatic logic [7:0] pk(bit s, bit z, bit ac, bit p, bit c);
    return {s, z, 1'b0, ac, 1'b0, p, 1'b1, c};
  endfunction

  // Independent reference built from the requirement text (codes 0..16, 19..31)
  function automatic logic [15:0] model(int op, int a, int b, logic [7:0] f);
    bit s = f[7], z = f[6], ac = f[4], p = f[2], c = f[0];
    int r = a, t, cin;
    bit szp = 0;
    case (op)
      0, 1: begin cin = (op == 1) ? int'(c) : 0; t = a + b + cin;
              ac = ((a % 16) + (b % 16) + cin) > 15; c = t > 255; r = t % 256; szp = 1; end
      2, 3, 4: begin cin = (op == 3) ? int'(c) : 0; t = a - b - cin;
              ac = ((a % 16) - (b % 16) - cin) < 0; c = t < 0; r = (t + 256) % 256; szp = 1; end
      5: begin r = a & b; c = 0; ac = 0; szp = 1; end
      6: begin r = a ^ b; c = 0; ac = 0; szp = 1; end
      7: begin r = a | b; c = 0; ac = 0; szp = 1; end
      8: begin ac = (a % 16) == 15; r = (a + 1) % 256; szp = 1; end
      9: begin ac = (a % 16) == 0;  r = (a + 255) % 256; szp = 1; end
      10: begin c = a >= 128; r = ((a * 2) % 256) + int'(c); end
      11: begin c = a % 2; r = a / 2 + (c ? 128 : 0); end
      12: begin r = ((a * 2) % 256) + int'(c); c = a >= 128; end
      13: begin r = a / 2 + (c ? 128 : 0); c = a % 2; end
      14: r = 255 - a;
      15: c = 1;
      16: c = !c;
      default: ;
    endcase
    if (szp) begin
      s = r >= 128; z = r == 0; p = ($countones(8'(r)) % 2) == 0;
    end
    if (op == 4) r = a;
    return {8'(r), pk(s, z, ac, p, c)};
  endfunction

  task automatic drive(int op, logic [7:0] a, logic [7:0] b, logic [7:0] f,
                       logic [15:0] pa, logic [15:0] pb,
                       logic [7:0] er, logic [7:0] ef, logic [15:0] ep, string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; op_in = 5'(op); acc_in = a; opnd_in = b;
    flags_in = f; pair_a = pa; pair_b = pb;
    e.r = er; e.f = ef; e.p = ep; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic drive_m(int op, logic [7:0] a, logic [7:0] b, logic [7:0] f, string tag);
    logic [15:0] m;
    logic [15:0] pa, pb;
    m  = model(op, a, b, f);
    pa = 16'($urandom); pb = 16'($urandom);
    drive(op, a, b, f, pa, pb, m[15:8], m[7:0], pa + pb, tag);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected output r=%h f=%h, expected none", "R1", result, flags_out);
      end else begin
        e = sb.pop_front();
        if (result !== e.r || flags_out !== e.f || pair_sum !== e.p) begin
          errors++;
          $display("FAIL %s: actual r=%h f=%h p=%h, expected r=%h f=%h p=%h",
                   e.tag, result, flags_out, pair_sum, e.r, e.f, e.p);
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    checks++;
    if (out_valid !== 1'b0 || result !== 8'h00 || flags_out !== 8'h02 || pair_sum !== 16'h0) begin
      errors++;
      $display("FAIL R1: actual v=%b r=%h f=%h p=%h, expected v=0 r=00 f=02 p=0000",
               out_valid, result, flags_out, pair_sum);
    end

    // R2 directed: 0xFF+0x01 wraps to zero with C, AC, Z, P
    drive(0, 8'hFF, 8'h01, 8'h00, 16'h0, 16'h0, 8'h00, 8'h57, 16'h0, "R2");
    // R3 directed: 0x00-0x01 borrows
    drive(2, 8'h00, 8'h01, 8'h00, 16'h0, 16'h0, 8'hFF, 8'h97, 16'h0, "R3");
    // R4 directed: compare equal keeps accumulator, sets Z
    drive(4, 8'h42, 8'h42, 8'h01, 16'h0, 16'h0, 8'h42, 8'h46, 16'h0, "R4");
    // R6: increment from 0xFF keeps carry=1
    drive(8, 8'hFF, 8'h00, 8'h01, 16'h0, 16'h0, 8'h00, 8'h57, 16'h0, "R6");
    // R7: rotate left through carry
    drive(12, 8'h80, 8'h00, 8'hD4, 16'h0, 16'h0, 8'h00, 8'hD7, 16'h0, "R7");
    // R9 decimal adjust cases
    drive(17, 8'h7D, 8'h00, 8'h02, 16'h0, 16'h0, 8'h83, 8'h92, 16'h0, "R9");
    drive(17, 8'h9A, 8'h00, 8'h02, 16'h0, 16'h0, 8'h00, 8'h57, 16'h0, "R9");
    drive(17, 8'h02, 8'h00, 8'h12, 16'h0, 16'h0, 8'h08, 8'h02, 16'h0, "R9");
    drive(17, 8'h15, 8'h00, 8'h03, 16'h0, 16'h0, 8'h75, 8'h03, 16'h0, "R9");
    // R10 pair add overflow keeps other flags, result = acc
    drive(18, 8'h5A, 8'h00, 8'hD4, 16'hFFFF, 16'h0001, 8'h5A, 8'hD7, 16'h0000, "R10");
    drive(18, 8'h11, 8'h00, 8'h01, 16'h1234, 16'h0100, 8'h11, 8'h02, 16'h1334, "R10");
    // R11 unassigned code, garbage in fixed bits
    drive(25, 8'h3C, 8'hAA, 8'hFF, 16'h1, 16'h2, 8'h3C, 8'hD7, 16'h3, "R11");
    // R8 set carry
    drive(15, 8'h99, 8'h00, 8'h00, 16'h0, 16'h0, 8'h99, 8'h03, 16'h0, "R8");

    // Random sweep over codes with independent model
    for (int i = 0; i < 600; i++) begin
      int op;
      string tg;
      op = int'($urandom_range(0, 16));
      if (i % 40 == 0) op = 19 + int'($urandom_range(0, 12));
      case (op)
        0, 1: tg = "R2";
        2, 3: tg = "R3";
        4: tg = "R4";
        5, 6, 7: tg = "R5";
        8, 9: tg = "R6";
        10, 11, 12, 13: tg = "R7";
        14, 15, 16: tg = "R8";
        default: tg = "R11";
      endcase
      drive_m(op, 8'($urandom), 8'($urandom), 8'($urandom), tg);
    end

    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R1: actual %0d pending results, expected 0", sb.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule